// File: doc/BRIEF.md
# SPI Command Transaction Engine

This block is an SPI master that runs one framed transaction at a time against a configuration slave. A transaction always opens with a 32-bit command word. What follows depends on the selected kind. A bare command ends there. A status read clocks in four more bytes and assembles them into a 32-bit status word. A page write shifts out sixteen data bytes after the command. Chip select stays low from the first bit to the last bit of the frame.

After chip select is released, the engine waits for a settle time before it raises its done pulse. The settle time is given per transaction in microseconds and converted to system clocks. The user starts a transaction with a one-cycle request that carries the command, the kind, the page bytes and the delay. It waits for `done`, then reads `status` if the transaction was a status read.

The serial clock runs at `CLK_MHZ / (2*HALF_DIV)` MHz. A parameter set that would push it above 66 MHz stops elaboration with an error.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, `mosi` is 0, `busy` is 0, `done` is 0 and `status` is 0.
- R2: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until `done` rises, and `done` is only high while `busy` is low. A `start` that arrives while busy has no effect on the frame in progress or on `status`.
- R3: Each transaction makes exactly one low period of `cs_n`, and that period lasts the whole frame. The frame length is set by `kind`: 2'b00 gives 32 bits (command only), 2'b01 gives 64 bits (status read), 2'b10 gives 160 bits (page write), and 2'b11 is treated as command only.
- R4: The serial interface uses SPI mode 0. `sck` is low whenever `cs_n` is high. Each `sck` half period lasts HALF_DIV system clocks. `mosi` changes only on a falling edge of `sck`. `miso` is sampled on the rising edge.
- R5: Bits go out most significant bit first. `cmd[31]` is the first bit. In a page write, `page[127]` follows `cmd[0]`, so page byte 0 sits in `page[127:120]`.
- R6: During the read phase of a status read, `mosi` is 0. The 32 bits sampled after the command form `status`, with the first received bit in `status[31]`. Only status-read transactions change `status`, and it updates in the cycle `cs_n` rises.
- R7: After `cs_n` rises, `busy` stays high and `done` rises exactly `delay_us*CLK_MHZ + 1` system clocks later.
- R8: `done` is a single-cycle pulse, given once per transaction.
- R9: The `sck` frequency `CLK_MHZ/(2*HALF_DIV)` MHz never exceeds 66 MHz. Parameters that would exceed it are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Transaction request, taken when idle |
| kind | input | 2 | Transaction kind: command, status read, page write |
| cmd | input | 32 | Command word, bits 31:24 hold the opcode |
| page | input | 128 | Page data, byte 0 in bits 127:120 |
| delay_us | input | DLY_W | Settle time after deselect, in microseconds |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 32 | Last status word read back |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
The in-module assertions check the properties that hold on every cycle:
- `sck` stays idle while deselected.
- `mosi` moves only on falling edges inside a frame.
- `done` is a lone pulse and never overlaps `busy`.
- `busy` persists across the deselect edge.
- `status` changes only when a frame closes.

The bench's reference model is needed for the properties that depend on stimulus:
- the exact bit order of command, page and zero-filled read phase;
- the frame length per kind;
- the assembly of the status word from `miso`;
- the exact settle count;
- starts that are ignored mid-frame;
- a start held high across `done`.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int CLK_MHZ  = 125,
  parameter int HALF_DIV = 2,
  parameter int DLY_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       kind,
  input  logic [31:0]      cmd,
  input  logic [127:0]     page,
  input  logic [DLY_W-1:0] delay_us,
  output logic             busy,
  output logic             done,
  output logic [31:0]      status,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);

  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int DW = DLY_W + $clog2(CLK_MHZ + 1);

  if (CLK_MHZ * 1000 > 66000 * 2 * HALF_DIV) begin : g_sck_too_fast
    $error("sck would exceed 66 MHz");
  end

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_WAIT} st_t;

  st_t             st;
  logic [HW-1:0]   cnt;
  logic [7:0]      bitn;
  logic [7:0]      last;
  logic [159:0]    tx;
  logic [31:0]     rx;
  logic [1:0]      kind_q;
  logic [DW-1:0]   dcnt;

  assign busy = (st != S_IDLE);
  assign cs_n = (st != S_XFER);
  assign mosi = !cs_n && tx[159];
  assign last = (kind_q == 2'b01) ? 8'd63 : (kind_q == 2'b10) ? 8'd159 : 8'd31;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sck    <= 1'b0;
      tx     <= '0;
      rx     <= '0;
      kind_q <= 2'b00;
      dcnt   <= '0;
      done   <= 1'b0;
      status <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_XFER;
          cnt    <= '0;
          bitn   <= '0;
          kind_q <= kind;
          tx     <= (kind == 2'b10) ? {cmd, page} : {cmd, 128'b0};
          dcnt   <= DW'(delay_us) * DW'(CLK_MHZ);
        end
        S_XFER: begin
          if (cnt == HW'(HALF_DIV - 1)) begin
            cnt <= '0;
            sck <= ~sck;
            if (!sck) begin
              rx <= {rx[30:0], miso};
            end else begin
              tx <= {tx[158:0], 1'b0};
              if (bitn == last) begin
                st <= S_WAIT;
                if (kind_q == 2'b01) status <= rx;
              end else begin
                bitn <= bitn + 8'd1;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (dcnt == '0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            dcnt <= dcnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SCK_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);  // R4
  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $fell(sck));  // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R2
  AST_BUSY_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy);  // R7
  AST_STATUS_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> $rose(cs_n));  // R6

endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
  localparam int CLK_MHZ = 125;
  localparam int H = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b1;
  logic [1:0] kind = 2'b00;
  logic [31:0] cmd = '0;
  logic [127:0] page = '0;
  logic [15:0] delay_us = '0;
  logic busy, done, sck, cs_n, mosi;
  logic [31:0] status;

  spi_cmd_engine #(.CLK_MHZ(CLK_MHZ), .HALF_DIV(H), .DLY_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .cmd(cmd), .page(page),
    .delay_us(delay_us), .busy(busy), .done(done), .status(status), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #4 clk = ~clk;

  int vec = 0, mis = 0, cyc = 0;
  bit compare_on = 1'b0;
  logic [31:0] resp = '0;

  // behavioural reference model
  bit m_act = 1'b0, m_done = 1'b0;
  int m_e = 0, m_n = 32, m_d = 0;
  logic [159:0] m_fr = '0;
  logic [1:0] m_kind = 2'b00;
  logic [31:0] m_resp = '0, m_status = '0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      mis++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      mis++;
      $display("FAIL watchdog expired");
      summary();
    end
    m_done = 1'b0;
    if (!rst_n) begin
      m_act = 1'b0; m_status = '0;
    end else if (m_act) begin
      m_e++;
      if (m_e == 2*m_n*H && m_kind == 2'b01) m_status = m_resp;
      if (m_e == 2*m_n*H + m_d + 1) begin m_act = 1'b0; m_done = 1'b1; end
    end else if (start) begin
      m_act = 1'b1; m_e = 0; m_kind = kind; m_resp = resp;
      m_fr = (kind == 2'b10) ? {cmd, page} : {cmd, 128'b0};
      m_n = (kind == 2'b01) ? 64 : (kind == 2'b10) ? 160 : 32;
      m_d = int'(delay_us) * CLK_MHZ;
    end
  end

  // slave model drives miso, junk ones outside the read phase
  always @(negedge clk) begin
    int j;
    j = m_e / (2*H);
    if (m_act && m_e < 2*m_n*H && m_kind == 2'b01 && j >= 32 && j < 64) miso <= m_resp[63-j];
    else miso <= 1'b1;
  end

  int hi_run = 0, cs_falls = 0, dones = 0;
  logic cs_prev = 1'b1;
  always @(negedge clk) begin
    if (compare_on) begin
      logic e_cs, e_sck, e_mosi, e_busy;
      e_busy = m_act; e_cs = 1'b1; e_sck = 1'b0; e_mosi = 1'b0;
      if (m_act && m_e < 2*m_n*H) begin
        e_cs = 1'b0;
        e_sck = ((m_e / H) % 2) == 1;
        e_mosi = m_fr[159 - m_e/(2*H)];
      end
      chk("R2", "busy", 32'(busy), 32'(e_busy));
      chk("R3", "cs_n", 32'(cs_n), 32'(e_cs));
      chk("R4", "sck", 32'(sck), 32'(e_sck));
      chk((m_kind == 2'b01 && m_e >= 64*H) ? "R6" : "R5", "mosi", 32'(mosi), 32'(e_mosi));
      chk("R6", "status", status, m_status);
      chk("R7", "done", 32'(done), 32'(m_done));
      if (sck) hi_run++;
      else if (hi_run != 0) begin
        chk("R9", "sck high width", 32'(hi_run), 32'(H));
        chk("R9", "sck within 66 MHz", 32'(1000.0 / (2.0 * hi_run * 8.0) <= 66.0), 32'd1);
        hi_run = 0;
      end
      if (cs_prev && !cs_n) cs_falls++;
      if (done) dones++;
      cs_prev = cs_n;
    end
  end

  task automatic fire(logic [1:0] k, logic [31:0] c, logic [127:0] p, logic [15:0] d);
    @(negedge clk);
    kind = k; cmd = c; page = p; delay_us = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_txn();
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R3", "single cs_n frame", 32'(cs_falls), 32'd1);
    chk("R8", "done pulses", 32'(dones), 32'd1);
    cs_falls = 0; dones = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "cs_n", 32'(cs_n), 32'd1);
    chk("R1", "sck", 32'(sck), 32'd0);
    chk("R1", "mosi", 32'(mosi), 32'd0);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "status", status, 32'd0);
    rst_n = 1'b1;
    compare_on = 1'b1;
    // command only, no delay (R3, R5, R7)
    fire(2'b00, 32'hC608_0000, '0, 16'd0);
    finish_txn();
    // status read with 1 us settle (R6, R7)
    resp = 32'hA5C3_0F1E;
    fire(2'b01, 32'h3C00_0000, '0, 16'd1);
    finish_txn();
    // page write (R5)
    fire(2'b10, 32'h7000_0001, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 16'd0);
    finish_txn();
    // start while busy is ignored (R2)
    resp = 32'h1234_5678;
    fire(2'b01, 32'h3C00_0000, '0, 16'd0);
    repeat (20) @(negedge clk);
    kind = 2'b10; cmd = 32'hFFFF_FFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_txn();
    // kind 3 acts as command only; status unchanged (R3, R6)
    fire(2'b11, 32'h79FF_00FF, '1, 16'd0);
    finish_txn();
    // start held across done: back-to-back frames (R2)
    resp = 32'h8000_0001;
    @(negedge clk);
    kind = 2'b01; cmd = 32'h3C00_0000; delay_us = 16'd0; start = 1'b1;
    while (!done) @(negedge clk);
    while (!busy) @(negedge clk);
    start = 1'b0;
    cs_falls = 0; dones = 0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule